// File: doc/BRIEF.md
# Mode-Selectable Multi-Function Register

This block is a parallel register of parameterised width. A two-bit operation code picks its next value. Each rising clock edge performs one of four operations on every bit at once:

- keep the current contents;
- invert every bit;
- force every bit to zero, at the edge only;
- capture the parallel data bus.

An active-low asynchronous reset forces the contents to zero at power-on, whatever the operation code holds.

Every bit is its own cell: one D flip-flop and a four-way selector. The selector's inputs are the bit itself, its inverse, a constant zero and the matching data bit. All four candidates exist side by side, and the operation code picks which one reaches the flip-flop. The four operations act as the named modes of the block:

| Mode | Code | Operation at the edge |
|------|------|-----------------------|
| HOLD | 00 | keep |
| FLIP | 01 | invert |
| ZERO | 10 | clear |
| LOAD | 11 | capture |

No mode has a memory of its own. Any mode may follow any other from one edge to the next, so every mode-to-mode transition is legal.

Top module: `mfreg_top`

## Requirements
- R1: While `rst_n` is low, `q` is all zeros, regardless of `mode` and `din`. The reset acts asynchronously: `q` clears without waiting for a clock edge.
- R2: With `mode` = 2'b00 (HOLD) at a rising edge, `q` keeps its value.
- R3: With `mode` = 2'b01 (FLIP) at a rising edge, every bit of `q` becomes its complement.
- R4: With `mode` = 2'b10 (ZERO), `q` becomes all zeros at the rising edge, and not before that edge.
- R5: With `mode` = 2'b11 (LOAD) at a rising edge, `q` takes the value of `din`.
- R6: The operation index is {mode[1], mode[0]}, with mode[1] as the more significant bit. Each bit's next value is chosen from its four candidates (own value, inverse, zero, data bit) by that index.
- R7: Changes to `mode` or `din` between rising edges leave `q` unchanged. Only the values present at the edge matter.
- R8: Two FLIP edges in a row return `q` to the value it had before the first of them.
- R9: The width is the parameter `WIDTH` (default 4). At every width each bit behaves as R2 to R6 describe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset to zero |
| mode | input | 2 | Operation code, bit 1 more significant |
| din | input | WIDTH | Parallel data captured in LOAD |
| q | output | WIDTH | Register contents |

## Verification
The bench builds two copies of the block side by side: one at the default width of 4 and one with `WIDTH` = 12. The 4-bit copy runs the vector table and the directed cases, where every bit pattern of the register is small enough to reason about. The 12-bit copy shows that the generated per-bit cells stay independent at a width other than the default. Both copies then follow a pseudo-random sequence of operation codes and data, checked every cycle against a reference model.

// File: rtl/mfreg_pkg.sv
package mfreg_pkg;

    localparam int MODE_W = 2;

    // Operation code; index equals {mode[1], mode[0]} (R6)
    typedef enum logic [MODE_W-1:0] {
        MODE_HOLD = 2'b00,
        MODE_FLIP = 2'b01,
        MODE_ZERO = 2'b10,
        MODE_LOAD = 2'b11
    } mode_e;

endpackage

// File: rtl/mfreg_sel4.sv
module mfreg_sel4
    import mfreg_pkg::*;
(
    input  mode_e sel,
    input  logic  keep_v,
    input  logic  flip_v,
    input  logic  zero_v,
    input  logic  load_v,
    output logic  y
);

    always_comb begin
        unique case (sel)
            MODE_HOLD: y = keep_v;
            MODE_FLIP: y = flip_v;
            MODE_ZERO: y = zero_v;
            MODE_LOAD: y = load_v;
            default:   y = keep_v;
        endcase
    end

endmodule

// File: rtl/mfreg_cell.sv
module mfreg_cell
    import mfreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode,
    input  logic  d_bit,
    output logic  q_bit
);

    logic next_bit;

    // All four candidates formed in parallel, one picked (R6)
    mfreg_sel4 u_sel (
        .sel    (mode),
        .keep_v (q_bit),
        .flip_v (~q_bit),
        .zero_v (1'b0),
        .load_v (d_bit),
        .y      (next_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_bit <= 1'b0;
        end else begin
            q_bit <= next_bit;
        end
    end

    // R8: two inversions in a row restore the bit
    p_double_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FLIP) ##1 (mode == MODE_FLIP) |=> (q_bit == $past(q_bit, 2)));

endmodule

// File: rtl/mfreg_top.sv
module mfreg_top
    import mfreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);

    mode_e op;
    assign op = mode_e'(mode);

    // One flip-flop plus selector per bit (R9)
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        mfreg_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (op),
            .d_bit (din[b]),
            .q_bit (q[b])
        );
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |-> (q == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (q == $past(q)));

    p_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (q == ~$past(q)));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (q == '0));

    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> (q == $past(din)));

endmodule

// File: tb/test_mfreg_top.sv
module test_mfreg_top;

    localparam int WN = 4;
    localparam int WW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'b11;
    logic [WN-1:0] din = '1;
    logic [WW-1:0] din_w = '1;
    logic [WN-1:0] q;
    logic [WW-1:0] q_w;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mfreg_top #(.WIDTH(WN)) i_mfreg_top (
        .clk(clk), .rst_n(rst_n), .mode(mode), .din(din), .q(q)
    );

    mfreg_top #(.WIDTH(WW)) i_mfreg_top_wide (
        .clk(clk), .rst_n(rst_n), .mode(mode), .din(din_w), .q(q_w)
    );

    // {mode, din, expected q}, starting from q = 0
    localparam logic [9:0] VEC [0:11] = '{
        {2'b11, 4'hA, 4'hA},
        {2'b00, 4'h5, 4'hA},
        {2'b01, 4'h0, 4'h5},
        {2'b01, 4'hF, 4'hA},
        {2'b10, 4'hF, 4'h0},
        {2'b01, 4'h0, 4'hF},
        {2'b11, 4'h3, 4'h3},
        {2'b00, 4'hC, 4'h3},
        {2'b01, 4'h3, 4'hC},
        {2'b11, 4'h6, 4'h6},
        {2'b10, 4'h9, 4'h0},
        {2'b10, 4'hF, 4'h0}
    };

    task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] m, input logic [WN-1:0] d);
        @(negedge clk);
        mode = m;
        din  = d;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [WW-1:0] model(input logic [1:0] m, input logic [WW-1:0] cur,
                                             input logic [WW-1:0] d);
        case (m)
            2'b00:   return cur;
            2'b01:   return ~cur;
            2'b10:   return '0;
            default: return d;
        endcase
    endfunction

    initial begin
        logic [15:0] lfsr;
        logic [WN-1:0] ref_n;
        logic [WW-1:0] ref_w;

        // R1: reset holds zero against LOAD of all ones
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset narrow", {8'h0, q}, '0);
        chk("R1 reset wide", q_w, '0);
        @(negedge clk);
        rst_n = 1'b1;
        mode = 2'b00;

        // R6: vector table through all codes
        for (int i = 0; i < 12; i++) begin
            step(VEC[i][9:8], VEC[i][7:4]);
            chk($sformatf("R6 vector %0d", i), {8'h0, q}, {8'h0, VEC[i][3:0]});
        end

        // R2: hold with changing data
        step(2'b11, 4'h9);
        step(2'b00, 4'h6);
        chk("R2 hold", {8'h0, q}, 12'h009);

        // R3 and R8: flip twice
        step(2'b01, 4'h0);
        chk("R3 flip", {8'h0, q}, 12'h006);
        step(2'b01, 4'h0);
        chk("R8 double flip", {8'h0, q}, 12'h009);

        // R5: load
        step(2'b11, 4'hF);
        chk("R5 load", {8'h0, q}, 12'h00F);

        // R4: clear waits for the edge
        @(negedge clk);
        mode = 2'b10;
        #2;
        chk("R4 before edge", {8'h0, q}, 12'h00F);
        @(posedge clk);
        #1;
        chk("R4 after edge", {8'h0, q}, 12'h000);

        // R7: wiggle between edges, only edge value counts
        step(2'b11, 4'hA);
        @(negedge clk);
        mode = 2'b11; din = 4'h5;
        #1 din = 4'h3;
        #1 mode = 2'b01;
        #1 mode = 2'b10;
        #1 mode = 2'b11; din = 4'hC;
        chk("R7 between edges", {8'h0, q}, 12'h00A);
        @(posedge clk);
        #1;
        chk("R7 edge value", {8'h0, q}, 12'h00C);

        // R1: asynchronous reset between edges
        @(negedge clk);
        mode = 2'b00;
        #1 rst_n = 1'b0;
        #1;
        chk("R1 async narrow", {8'h0, q}, '0);
        chk("R1 async wide", q_w, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: random sequence against model at two widths
        lfsr = 16'hACE1;
        ref_n = '0;
        ref_w = '0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            mode  = lfsr[1:0];
            din   = lfsr[5:2];
            din_w = lfsr[15:4];
            ref_n = WN'(model(lfsr[1:0], {8'h0, ref_n}, {8'h0, lfsr[5:2]}));
            ref_w = model(lfsr[1:0], ref_w, lfsr[15:4]);
            lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            @(posedge clk);
            #1;
            chk($sformatf("R6 random narrow %0d", k), {8'h0, q}, {8'h0, ref_n});
            chk($sformatf("R9 random wide %0d", k), q_w, ref_w);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule